// File: doc/BRIEF.md
# Programmable Baud Rate Generator Bank

This block holds a set of independent rate generators. Each generator turns the system clock into a one-cycle enable tick that repeats at a programmed interval. A serial receiver samples its line on these ticks, so software programs each generator for sixteen times the wanted line rate. Each generator has its own configuration word. The word holds an enable bit, a 12-bit divide value that stores the divisor minus one, and a select bit that places a divide-by-16 prescaler ahead of the counter. The prescaler is there for slow rates whose divisor does not fit in 12 bits.

A routing stage sits behind the generators. Every serial channel has its own select field, and that field picks which generator feeds the channel's tick, so any generator can drive any channel. A write to a generator's word takes effect on the next clock edge. The write restarts that generator's counter and prescaler, so the first tick at the new rate arrives one full period after the write.

Configuration word layout (CFG_W = DIV_W + 2 = 14 bits): bit 0 selects the prescaler, bits [12:1] hold the divide value D, and bit 13 enables the generator.

Top module: `baud_gen_bank`

## Requirements
- R1: After a synchronous active-low reset, every generator is disabled and all `gen_tick` and `ch_tick` bits are 0 until a configuration write enables a generator.
- R2: With bit 13 set and bit 0 clear, the generator pulses `gen_tick` high for exactly one cycle every D+1 cycles, where D is the value in bits [12:1].
- R3: With bits 13 and 0 both set, the tick period is 16×(D+1) cycles.
- R4: While a generator's enable bit (bit 13) is clear, its `gen_tick` stays 0.
- R5: A write to a generator, with `cfg_we[g]` high at a clock edge, restarts it. The first tick is sampled after the edge that lies exactly one period after the write edge, and one more at each multiple of that period.
- R6: If a write lands on the same edge at which the generator would otherwise tick, the write wins and no tick is produced at that edge.
- R7: D = 0 without the prescaler gives a tick on every cycle. D = 4095 gives a period of 4096 cycles.
- R8: `ch_tick[c]` equals `gen_tick[k]`, where k is the 2-bit field `route_sel[2c+1:2c]`. Any generator may feed any number of channels.
- R9: A write to one generator does not disturb the tick phase or rate of any other generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | NUM_GEN (4) | Per-generator write strobe for the configuration word |
| cfg_wdata | input | CFG_W (14) | Configuration word: [0] prescaler select, [12:1] divide value, [13] enable |
| route_sel | input | NUM_CH×SEL_W (8) | Per-channel 2-bit generator select, channel c at [2c+1:2c] |
| gen_tick | output | NUM_GEN (4) | Registered one-cycle tick of each generator |
| ch_tick | output | NUM_CH (4) | Tick delivered to each serial channel after routing |

## Verification
Two functions of a generator can fall on the same edge: the counter reaching zero, which reloads it and raises a tick, and a configuration write, which restarts it. The bench provokes this collision in two ways. A directed case rewrites a generator exactly one period after its previous write. Random writes also land on tick edges, and those are tallied. The bench judges the outcome against a model that measures the period from the last write edge. It expects a low tick at the collision edge and the first new tick one full new period later.

// File: rtl/baud_pkg.sv
// Package: shared field positions and defaults for the baud generator bank.
// Assumes the configuration word is packed as prescale | divide | enable,
// low bit first, with the divide field DIV_W bits wide.
package baud_pkg;
    localparam int unsigned BG_DIV_W_DEF  = 12;  // default divide field width
    localparam int unsigned BG_PRE_RATIO  = 16;  // prescaler division ratio
    localparam int unsigned BG_PRE_BIT    = 0;   // prescaler select position
    localparam int unsigned BG_DIV_LSB    = 1;   // divide field low bit
endpackage

// File: rtl/baud_prescale.sv
// Module: baud_prescale
// Free-running modulo-RATIO counter that emits a one-cycle strobe at every
// RATIO-th cycle in which it is running. A clear puts it back to phase zero.
// Assumes RATIO >= 2.
module baud_prescale #(
    parameter int unsigned RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic strobe
);
    localparam int unsigned PW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    logic [PW-1:0] phase;

    // Advance the phase while running; wrap at RATIO-1; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= '0;
        end else if (run) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    // Strobe in the last phase of each prescaler round.
    always_comb strobe = run && (phase == LAST);
endmodule

// File: rtl/baud_div_counter.sv
// Module: baud_div_counter
// Down counter that counts step pulses. On a step at zero it reloads from
// reload_val and raises a registered one-cycle tick. A load restarts it from
// load_val and suppresses the tick at that edge (the load wins).
module baud_div_counter #(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic             step,
    input  logic [DIV_W-1:0] reload_val,
    output logic             tick
);
    logic [DIV_W-1:0] count;

    // Count down on each step, reload and tick at zero; a load takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            tick  <= 1'b0;
        end else if (load) begin
            count <= load_val;
            tick  <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (step) begin
                if (count == '0) begin
                    count <= reload_val;
                    tick  <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/baud_gen_unit.sv
// Module: baud_gen_unit
// One rate generator. It holds its configuration (enable, prescale, divide),
// an optional prescaler and the divide counter. A write latches the new
// configuration and restarts both counting stages on the same edge.
module baud_gen_unit #(
    parameter int unsigned DIV_W     = baud_pkg::BG_DIV_W_DEF,
    parameter int unsigned PRE_RATIO = baud_pkg::BG_PRE_RATIO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_en,
    input  logic             wr_pre,
    input  logic [DIV_W-1:0] wr_div,
    output logic             tick,
    output logic             en_q,
    output logic             pre_q,
    output logic             div_zero
);
    logic [DIV_W-1:0] div_q;
    logic             pre_strobe;
    logic             step;

    // Configuration holding register, cleared to disabled at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            pre_q <= 1'b0;
            div_q <= '0;
        end else if (wr) begin
            en_q  <= wr_en;
            pre_q <= wr_pre;
            div_q <= wr_div;
        end
    end

    // Prescaler present only when the ratio actually divides.
    generate
        if (PRE_RATIO > 1) begin : g_pre
            baud_prescale #(.RATIO(PRE_RATIO)) u_pre (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (wr),
                .run    (en_q && pre_q),
                .strobe (pre_strobe)
            );
        end else begin : g_nopre
            always_comb pre_strobe = 1'b1;
        end
    endgenerate

    // Counter advances each cycle, or on prescaler strobes when selected.
    always_comb step = en_q && (pre_q ? pre_strobe : 1'b1);

    baud_div_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr),
        .load_val   (wr_div),
        .step       (step),
        .reload_val (div_q),
        .tick       (tick)
    );

    // Flag for the checker: divide value of one cycle.
    always_comb div_zero = (div_q == '0);
endmodule

// File: rtl/baud_route.sv
// Module: baud_route
// Channel routing matrix: each channel takes the tick of the generator named
// by its own SEL_W-bit select field. Assumes every select value names an
// existing generator (NUM_GEN is a power of two).
module baud_route #(
    parameter int unsigned NUM_GEN = 4,
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned SEL_W   = 2
) (
    input  logic [NUM_GEN-1:0]      gen_tick,
    input  logic [NUM_CH*SEL_W-1:0] sel,
    output logic [NUM_CH-1:0]       ch_tick
);
    // One selector per channel.
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            always_comb ch_tick[c] = gen_tick[sel[c*SEL_W +: SEL_W]];
        end
    endgenerate
endmodule

// File: rtl/baud_gen_bank.sv
// Module: baud_gen_bank (top)
// Bank of NUM_GEN programmable rate generators plus the channel routing
// matrix. cfg_we selects which generator takes cfg_wdata on an edge.
// Word layout: [0] prescale, [DIV_W:1] divide value, [DIV_W+1] enable.
module baud_gen_bank #(
    parameter int unsigned NUM_GEN   = 4,
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned DIV_W     = baud_pkg::BG_DIV_W_DEF,
    parameter int unsigned PRE_RATIO = baud_pkg::BG_PRE_RATIO,
    localparam int unsigned SEL_W    = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1,
    localparam int unsigned CFG_W    = DIV_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_GEN-1:0]      cfg_we,
    input  logic [CFG_W-1:0]        cfg_wdata,
    input  logic [NUM_CH*SEL_W-1:0] route_sel,
    output logic [NUM_GEN-1:0]      gen_tick,
    output logic [NUM_CH-1:0]       ch_tick
);
    localparam int unsigned EN_BIT = DIV_W + 1;

    logic [NUM_GEN-1:0] gen_en;
    logic [NUM_GEN-1:0] gen_pre;
    logic [NUM_GEN-1:0] gen_div_zero;

    // One generator per index, all sharing the write data bus.
    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
            baud_gen_unit #(.DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO)) u_gen (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr       (cfg_we[g]),
                .wr_en    (cfg_wdata[EN_BIT]),
                .wr_pre   (cfg_wdata[baud_pkg::BG_PRE_BIT]),
                .wr_div   (cfg_wdata[baud_pkg::BG_DIV_LSB +: DIV_W]),
                .tick     (gen_tick[g]),
                .en_q     (gen_en[g]),
                .pre_q    (gen_pre[g]),
                .div_zero (gen_div_zero[g])
            );
        end
    endgenerate

    baud_route #(.NUM_GEN(NUM_GEN), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_route (
        .gen_tick (gen_tick),
        .sel      (route_sel),
        .ch_tick  (ch_tick)
    );
endmodule

// File: rtl/baud_gen_bank_chk.sv
// Module: baud_gen_bank_chk
// Assertion checker bound to baud_gen_bank. It watches the generator ticks
// against the held configuration, write strobes and the routed outputs.
module baud_gen_bank_chk #(
    parameter int unsigned NUM_GEN = 4,
    parameter int unsigned NUM_CH  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_GEN-1:0] cfg_we,
    input logic [NUM_GEN-1:0] gen_tick,
    input logic [NUM_CH-1:0]  ch_tick,
    input logic [NUM_GEN-1:0] gen_en,
    input logic [NUM_GEN-1:0] gen_pre,
    input logic [NUM_GEN-1:0] gen_div_zero
);
    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_a
            p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !gen_en[g] |-> !gen_tick[g]);
            p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_we[g] |=> !gen_tick[g]);
            p_one_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (gen_tick[g] && !gen_div_zero[g] && !cfg_we[g]) |=> !gen_tick[g]);
            p_pre_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (gen_tick[g] && gen_pre[g]) |=> !gen_tick[g]);
        end
    endgenerate

    p_route_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_tick) |-> (|gen_tick));
endmodule

bind baud_gen_bank baud_gen_bank_chk #(.NUM_GEN(NUM_GEN), .NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .gen_tick     (gen_tick),
    .ch_tick      (ch_tick),
    .gen_en       (gen_en),
    .gen_pre      (gen_pre),
    .gen_div_zero (gen_div_zero)
);

// File: tb/sim_baud_gen_bank.sv
// Bench for baud_gen_bank: directed corners then seeded random writes and
// route changes, checked against a period model counted from write edges.
module sim_baud_gen_bank;
    localparam int NG = 4;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_we = '0;
    logic [13:0] cfg_wdata = '0;
    logic [7:0]  route_sel = '0;
    logic [3:0]  gen_tick;
    logic [3:0]  ch_tick;

    int checks = 0;
    int fails = 0;
    int collisions = 0;
    bit done = 0;

    // Model state per generator
    bit m_en[NG];
    bit m_pre[NG];
    int m_div[NG];
    int m_n[NG];
    bit m_wr[NG];

    always #2 clk = ~clk;

    baud_gen_bank u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .route_sel(route_sel), .gen_tick(gen_tick), .ch_tick(ch_tick)
    );

    function automatic int period(int g);
        return (m_div[g] + 1) * (m_pre[g] ? 16 : 1);
    endfunction

    function automatic bit exp_tick(int g);
        return m_en[g] && m_n[g] > 0 && (m_n[g] % period(g)) == 0;
    endfunction

    function automatic logic [13:0] word(bit en, bit pre, int d);
        return {en, 12'(d), pre};
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, check at negedge.
    task automatic cyc(logic [3:0] we, logic [13:0] d, logic [7:0] rs);
        bit would;
        string tag;
        cfg_we = we; cfg_wdata = d; route_sel = rs;
        @(posedge clk);
        for (int g = 0; g < NG; g++) begin
            m_wr[g] = we[g];
            if (we[g]) begin
                would = m_en[g] && ((m_n[g] + 1) % period(g)) == 0;
                if (would) collisions++;
                m_en[g] = d[13]; m_pre[g] = d[0]; m_div[g] = int'(d[12:1]); m_n[g] = 0;
            end else begin
                m_n[g]++;
            end
        end
        @(negedge clk);
        for (int g = 0; g < NG; g++) begin
            if (m_wr[g]) tag = "R5/R6";
            else if (!m_en[g]) tag = "R4";
            else if (m_pre[g]) tag = "R3";
            else if (m_div[g] == 0 || m_div[g] == 4095) tag = "R7";
            else if (|we) tag = "R2/R9";
            else tag = "R2";
            check(tag, gen_tick[g], exp_tick(g));
        end
        for (int c = 0; c < NC; c++)
            check("R8", ch_tick[c], exp_tick(int'(rs[2*c +: 2])));
    endtask

    initial begin
        logic [7:0] rs;
        void'($urandom(32'd1234));
        for (int g = 0; g < NG; g++) begin m_en[g] = 0; m_pre[g] = 0; m_div[g] = 0; m_n[g] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int g = 0; g < NG; g++) check("R1", gen_tick[g], 1'b0);
        rst_n = 1'b1;
        rs = 8'b11_10_01_00;
        for (int i = 0; i < 5; i++) cyc(4'b0000, 14'h3fff, rs);
        for (int g = 0; g < NG; g++) check("R1", gen_tick[g], 1'b0);

        // Directed: D=0 every cycle, D=4095, prescaled D=2, disabled D=1
        cyc(4'b0001, word(1, 0, 0), rs);
        cyc(4'b0010, word(1, 0, 4095), rs);
        cyc(4'b0100, word(1, 1, 2), rs);
        cyc(4'b1000, word(0, 0, 1), rs);
        for (int i = 0; i < 4200; i++) cyc(4'b0000, 14'h0, rs);

        // R6: rewrite gen0 with D=3 exactly one period after the prior write
        cyc(4'b0001, word(1, 0, 3), 8'h00);
        cyc(4'b0000, 14'h0, 8'h00);
        cyc(4'b0000, 14'h0, 8'h00);
        cyc(4'b0000, 14'h0, 8'h00);
        cyc(4'b0001, word(1, 0, 3), 8'h00);
        check("R6", gen_tick[0], 1'b0);
        for (int i = 0; i < 12; i++) cyc(4'b0000, 14'h0, 8'h00);

        // Random phase
        for (int i = 0; i < 20000; i++) begin
            logic [3:0]  we;
            logic [13:0] d;
            we = '0;
            d = 14'($urandom);
            if ($urandom_range(0, 31) == 0) begin
                we[$urandom_range(0, 3)] = 1'b1;
                d[12:1] = ($urandom_range(0, 7) == 0) ? 12'($urandom_range(0, 300))
                                                       : 12'($urandom_range(0, 12));
                d[0]  = ($urandom_range(0, 3) == 0);
                d[13] = ($urandom_range(0, 7) != 0);
            end
            if ($urandom_range(0, 15) == 0) rs = 8'($urandom);
            cyc(we, d, rs);
        end
        $display("write/tick collisions seen: %0d", collisions);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule